// File: doc/BRIEF.md
# Oldest-First Deflection Allocator for a Bufferless Mesh Router

This block decides, in a single cycle, where every flit that enters a bufferless 2D-mesh router leaves. Flits come in on up to four neighbour links (north, east, south, west) and one local injection slot. Each flit carries its full destination coordinates, an age stamp and a payload. The router holds no flit storage, so every accepted flit must get an output in the cycle it arrives. That output is the local eject port, a productive link, or a free link that moves the flit away from its destination (a deflection).

The allocator works in three stages. It first works out, from the router's own coordinates, which directions bring each flit closer to its destination. A `mode_multi` input selects how many of these directions a flit may ask for: only the single X-then-Y direction, or every productive direction. It then ranks the flits by age, oldest first, with a fixed slot order breaking ties. Finally it walks the ranked list and hands each flit a distinct output. The chosen flits are registered, and each leaves with its age stamp incremented.

The block has no state machine. Its only state is one output register stage, which is cleared by an asynchronous active-low reset.

Top module: `defl_allocator`

## Requirements
- R1: While reset is held, and in the first cycle after it, all `out_vld` bits and `ej_vld` are 0.
- R2: Every accepted flit appears on exactly one output, carrying its payload, on the clock edge after it is presented. Accepted flits are valid flits on existing links plus a non-stalled injection. No flit is held back, and nothing is emitted when no flit is presented.
- R3: A flit whose destination equals (`my_x`,`my_y`) is granted the eject port if it is the oldest such flit. Only one flit ejects per cycle. Other flits for this router are deflected to a network link.
- R4: When flits contend for one output, the flit with the larger age value gets it. The loser takes another free output.
- R5: Equal ages are ordered by slot index: north=0, east=1, south=2, west=3, injection=4. The lower index is served first.
- R6: With `mode_multi`=0, a flit requests only east or west while its X differs from `my_x`, and otherwise only north or south. East means larger X and north means larger Y.
- R7: With `mode_multi`=1, a flit requests every productive direction and gets the lowest-index one that is still free.
- R8: A flit with no free requested output goes to the lowest-index existing link that is still free.
- R9: Links off the mesh edge are never driven. A valid bit on an input from such a link is ignored.
- R10: `inj_stall` is 1 exactly when `inj_vld` is 1 and the number of valid arrivals on existing links is at least the number of existing links. A stalled injection flit is not emitted.
- R11: An emitted flit's age equals its input age plus one, saturating at the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | XW | Router X coordinate |
| my_y | input | YW | Router Y coordinate |
| mode_multi | input | 1 | 1: request all productive directions; 0: X-then-Y only |
| in_vld | input | 4 | Flit valid per neighbour link (N,E,S,W) |
| in_dst_x | input | 4×XW | Destination X per link |
| in_dst_y | input | 4×YW | Destination Y per link |
| in_age | input | 4×AGE_W | Age stamp per link |
| in_data | input | 4×DATA_W | Payload per link |
| inj_vld | input | 1 | Local injection flit valid |
| inj_dst_x | input | XW | Injection destination X |
| inj_dst_y | input | YW | Injection destination Y |
| inj_age | input | AGE_W | Injection age stamp |
| inj_data | input | DATA_W | Injection payload |
| inj_stall | output | 1 | Injection refused this cycle |
| out_vld | output | 4 | Registered flit valid per output link |
| out_dst_x | output | 4×XW | Registered destination X per link |
| out_dst_y | output | 4×YW | Registered destination Y per link |
| out_age | output | 4×AGE_W | Registered incremented age per link |
| out_data | output | 4×DATA_W | Registered payload per link |
| ej_vld | output | 1 | Registered eject valid |
| ej_dst_x | output | XW | Ejected flit destination X |
| ej_dst_y | output | YW | Ejected flit destination Y |
| ej_age | output | AGE_W | Ejected flit incremented age |
| ej_data | output | DATA_W | Ejected flit payload |

## Verification
The bench builds the block with its defaults: an 8×8 mesh, 8-bit ages and 16-bit payloads. With an 8×8 mesh, both an interior router with four links and corner routers at (0,0) and (7,7) with two links are within reach. This brings the edge-masking and injection-stall rules into play with a link count other than four. The 8-bit age lets the bench drive the all-ones stamp directly, which exercises saturation. Each payload is a unique tag, so every flit can be traced to the single output it took under contention, ties, ejection clashes and deflection.

// File: rtl/defl_pkg.sv
package defl_pkg;
    localparam int NUM_DIR  = 4;
    localparam int NUM_SLOT = 5;
    localparam int DIR_N    = 0;
    localparam int DIR_E    = 1;
    localparam int DIR_S    = 2;
    localparam int DIR_W    = 3;
    localparam int INJ_SLOT = 4;

    typedef logic [2:0] grant_t;
    typedef logic [2:0] slot_idx_t;

    localparam grant_t GNT_EJECT = 3'd4;
    localparam grant_t GNT_NONE  = 3'd7;
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
    import defl_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic               vld,
    input  logic               multi,
    input  logic [XW-1:0]      cur_x,
    input  logic [YW-1:0]      cur_y,
    input  logic [XW-1:0]      dst_x,
    input  logic [YW-1:0]      dst_y,
    output logic [NUM_DIR-1:0] want,
    output logic               want_ej
);
    logic go_e, go_w, go_n, go_s;

    always_comb begin
        go_e    = dst_x > cur_x;
        go_w    = dst_x < cur_x;
        go_n    = dst_y > cur_y;
        go_s    = dst_y < cur_y;
        want_ej = vld && (dst_x == cur_x) && (dst_y == cur_y);
        want    = '0;
        if (vld && !want_ej) begin
            want[DIR_E] = go_e;
            want[DIR_W] = go_w;
            if (multi || !(go_e || go_w)) begin
                want[DIR_N] = go_n;
                want[DIR_S] = go_s;
            end
        end
    end
endmodule

// File: rtl/defl_age_rank.sv
module defl_age_rank
    import defl_pkg::*;
#(
    parameter int NS    = 5,
    parameter int AGE_W = 8
) (
    input  logic [NS-1:0]            vld,
    input  logic [NS-1:0][AGE_W-1:0] age,
    output slot_idx_t [NS-1:0]       order
);
    localparam int KW = AGE_W + 1;

    slot_idx_t [NS-1:0] rank;
    logic [KW-1:0]      key_i, key_j;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            rank[i] = '0;
            key_i   = {vld[i], age[i]};
            for (int j = 0; j < NS; j++) begin
                key_j = {vld[j], age[j]};
                if (j != i && ((key_j > key_i) || (key_j == key_i && j < i)))
                    rank[i] = rank[i] + 3'd1;
            end
        end
    end

    always_comb begin
        order = '0;
        for (int i = 0; i < NS; i++)
            order[rank[i]] = slot_idx_t'(i);
    end
endmodule

// File: rtl/defl_port_assign.sv
module defl_port_assign
    import defl_pkg::*;
#(
    parameter int NS = 5,
    parameter int ND = 4
) (
    input  slot_idx_t [NS-1:0]      order,
    input  logic [NS-1:0]           vld,
    input  logic [NS-1:0]           want_ej,
    input  logic [NS-1:0][ND-1:0]   want,
    input  logic [ND-1:0]           link_ok,
    output grant_t [NS-1:0]         grant
);
    logic [ND-1:0] taken, cand;
    logic          ej_taken, picked;
    slot_idx_t     s;

    always_comb begin
        taken    = '0;
        ej_taken = 1'b0;
        cand     = '0;
        picked   = 1'b0;
        s        = '0;
        grant    = {NS{GNT_NONE}};
        for (int r = 0; r < NS; r++) begin
            s = order[r];
            if (vld[s]) begin
                if (want_ej[s] && !ej_taken) begin
                    grant[s] = GNT_EJECT;
                    ej_taken = 1'b1;
                end else begin
                    cand = want[s] & link_ok & ~taken;
                    if (cand == '0)
                        cand = link_ok & ~taken;
                    picked = 1'b0;
                    for (int d = 0; d < ND; d++) begin
                        if (cand[d] && !picked) begin
                            grant[s] = grant_t'(d);
                            taken[d] = 1'b1;
                            picked   = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/defl_allocator.sv
module defl_allocator
    import defl_pkg::*;
#(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8,
    parameter int AGE_W  = 8,
    parameter int DATA_W = 16,
    localparam int XW    = $clog2(MESH_X),
    localparam int YW    = $clog2(MESH_Y)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [XW-1:0]                 my_x,
    input  logic [YW-1:0]                 my_y,
    input  logic                          mode_multi,
    input  logic [NUM_DIR-1:0]            in_vld,
    input  logic [NUM_DIR-1:0][XW-1:0]    in_dst_x,
    input  logic [NUM_DIR-1:0][YW-1:0]    in_dst_y,
    input  logic [NUM_DIR-1:0][AGE_W-1:0] in_age,
    input  logic [NUM_DIR-1:0][DATA_W-1:0] in_data,
    input  logic                          inj_vld,
    input  logic [XW-1:0]                 inj_dst_x,
    input  logic [YW-1:0]                 inj_dst_y,
    input  logic [AGE_W-1:0]              inj_age,
    input  logic [DATA_W-1:0]             inj_data,
    output logic                          inj_stall,
    output logic [NUM_DIR-1:0]            out_vld,
    output logic [NUM_DIR-1:0][XW-1:0]    out_dst_x,
    output logic [NUM_DIR-1:0][YW-1:0]    out_dst_y,
    output logic [NUM_DIR-1:0][AGE_W-1:0] out_age,
    output logic [NUM_DIR-1:0][DATA_W-1:0] out_data,
    output logic                          ej_vld,
    output logic [XW-1:0]                 ej_dst_x,
    output logic [YW-1:0]                 ej_dst_y,
    output logic [AGE_W-1:0]              ej_age,
    output logic [DATA_W-1:0]             ej_data
);
    logic [NUM_DIR-1:0]                  link_ok, net_vld;
    logic [2:0]                          arrivals, n_links;
    logic [NUM_SLOT-1:0]                 s_vld, s_want_ej;
    logic [NUM_SLOT-1:0][XW-1:0]         s_x;
    logic [NUM_SLOT-1:0][YW-1:0]         s_y;
    logic [NUM_SLOT-1:0][AGE_W-1:0]      s_age;
    logic [NUM_SLOT-1:0][DATA_W-1:0]     s_data;
    logic [NUM_SLOT-1:0][NUM_DIR-1:0]    s_want;
    slot_idx_t [NUM_SLOT-1:0]            order;
    grant_t [NUM_SLOT-1:0]               grant;

    logic [NUM_DIR-1:0]                  nx_vld;
    logic [NUM_DIR-1:0][XW-1:0]          nx_x;
    logic [NUM_DIR-1:0][YW-1:0]          nx_y;
    logic [NUM_DIR-1:0][AGE_W-1:0]       nx_age;
    logic [NUM_DIR-1:0][DATA_W-1:0]      nx_data;
    logic                                nx_ej;
    logic [XW-1:0]                       nx_ej_x;
    logic [YW-1:0]                       nx_ej_y;
    logic [AGE_W-1:0]                    nx_ej_age;
    logic [DATA_W-1:0]                   nx_ej_data;

    function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
        return (&a) ? a : a + 1'b1;
    endfunction

    // Links present at this mesh position, and arrival bookkeeping
    always_comb begin
        link_ok[DIR_N] = (my_y != YW'(MESH_Y - 1));
        link_ok[DIR_E] = (my_x != XW'(MESH_X - 1));
        link_ok[DIR_S] = (my_y != '0);
        link_ok[DIR_W] = (my_x != '0);
        net_vld  = in_vld & link_ok;
        arrivals = '0;
        n_links  = '0;
        for (int d = 0; d < NUM_DIR; d++) begin
            arrivals = arrivals + 3'(net_vld[d]);
            n_links  = n_links + 3'(link_ok[d]);
        end
        inj_stall = inj_vld && (arrivals >= n_links);
    end

    always_comb begin
        s_vld  = {inj_vld && !inj_stall, net_vld};
        s_x    = {inj_dst_x, in_dst_x};
        s_y    = {inj_dst_y, in_dst_y};
        s_age  = {inj_age, in_age};
        s_data = {inj_data, in_data};
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_route
        defl_route_calc #(.XW(XW), .YW(YW)) i_route (
            .vld    (s_vld[g]),
            .multi  (mode_multi),
            .cur_x  (my_x),
            .cur_y  (my_y),
            .dst_x  (s_x[g]),
            .dst_y  (s_y[g]),
            .want   (s_want[g]),
            .want_ej(s_want_ej[g])
        );
    end

    defl_age_rank #(.NS(NUM_SLOT), .AGE_W(AGE_W)) i_rank (
        .vld  (s_vld),
        .age  (s_age),
        .order(order)
    );

    defl_port_assign #(.NS(NUM_SLOT), .ND(NUM_DIR)) i_assign (
        .order  (order),
        .vld    (s_vld),
        .want_ej(s_want_ej),
        .want   (s_want),
        .link_ok(link_ok),
        .grant  (grant)
    );

    // Steer granted slots onto output lanes
    always_comb begin
        nx_vld = '0; nx_x = '0; nx_y = '0; nx_age = '0; nx_data = '0;
        nx_ej = 1'b0; nx_ej_x = '0; nx_ej_y = '0; nx_ej_age = '0; nx_ej_data = '0;
        for (int s = 0; s < NUM_SLOT; s++) begin
            for (int p = 0; p < NUM_DIR; p++) begin
                if (grant[s] == grant_t'(p)) begin
                    nx_vld[p]  = 1'b1;
                    nx_x[p]    = s_x[s];
                    nx_y[p]    = s_y[s];
                    nx_age[p]  = age_step(s_age[s]);
                    nx_data[p] = s_data[s];
                end
            end
            if (grant[s] == GNT_EJECT) begin
                nx_ej      = 1'b1;
                nx_ej_x    = s_x[s];
                nx_ej_y    = s_y[s];
                nx_ej_age  = age_step(s_age[s]);
                nx_ej_data = s_data[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= '0; out_dst_x <= '0; out_dst_y <= '0; out_age <= '0; out_data <= '0;
            ej_vld  <= 1'b0; ej_dst_x <= '0; ej_dst_y <= '0; ej_age <= '0; ej_data <= '0;
        end else begin
            out_vld <= nx_vld; out_dst_x <= nx_x; out_dst_y <= nx_y;
            out_age <= nx_age; out_data <= nx_data;
            ej_vld  <= nx_ej; ej_dst_x <= nx_ej_x; ej_dst_y <= nx_ej_y;
            ej_age  <= nx_ej_age; ej_data <= nx_ej_data;
        end
    end
endmodule

// File: rtl/defl_allocator_chk.sv
module defl_allocator_chk
    import defl_pkg::*;
#(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8,
    parameter int AGE_W  = 8,
    localparam int XW    = $clog2(MESH_X),
    localparam int YW    = $clog2(MESH_Y)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [XW-1:0]                 my_x,
    input logic [YW-1:0]                 my_y,
    input logic [NUM_DIR-1:0]            in_vld,
    input logic                          inj_vld,
    input logic                          inj_stall,
    input logic [NUM_DIR-1:0]            out_vld,
    input logic [NUM_DIR-1:0][AGE_W-1:0] out_age,
    input logic                          ej_vld,
    input logic [XW-1:0]                 ej_dst_x,
    input logic [YW-1:0]                 ej_dst_y,
    input logic [AGE_W-1:0]              ej_age
);
    logic [NUM_DIR-1:0] edge_ok;
    int                 got_in, links;
    logic               armed;

    always_comb begin
        edge_ok = {my_x > '0, my_y > '0, int'(my_x) < MESH_X - 1, int'(my_y) < MESH_Y - 1};
        links   = $countones(edge_ok);
        got_in  = $countones(in_vld & edge_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    flit_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ($countones(out_vld) + int'(ej_vld)) ==
                  $past(got_in + int'(inj_vld && !inj_stall)));

    // R9
    edge_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_vld & ~$past(edge_ok)) == '0);

    // R10
    inj_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && !inj_stall) |-> got_in < links);

    // R10
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_stall |-> inj_vld);

    // R3
    eject_here_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ej_vld) |-> (ej_dst_x == $past(my_x) && ej_dst_y == $past(my_y)));

    // R11
    eject_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ej_vld |-> ej_age != '0);

    for (genvar p = 0; p < NUM_DIR; p++) begin : g_age
        // R11
        out_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[p] |-> out_age[p] != '0);
    end
endmodule

bind defl_allocator defl_allocator_chk #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .AGE_W(AGE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_vld(in_vld), .inj_vld(inj_vld), .inj_stall(inj_stall),
    .out_vld(out_vld), .out_age(out_age), .ej_vld(ej_vld),
    .ej_dst_x(ej_dst_x), .ej_dst_y(ej_dst_y), .ej_age(ej_age)
);

// File: tb/test_defl_allocator.sv
module test_defl_allocator;
    localparam int NV = 14;
    localparam logic [2:0] XX = 3'd7;

    typedef struct packed {
        logic       v;
        logic [2:0] x;
        logic [2:0] y;
        logic [7:0] age;
    } tflit_t;

    typedef struct packed {
        logic [2:0] mx;
        logic [2:0] my;
        logic       multi;
        tflit_t     f0, f1, f2, f3, f4;
        logic [2:0] e0, e1, e2, e3, e4;
        logic       stall;
    } tvec_t;

    localparam tflit_t NO = '{1'b0, 3'd0, 3'd0, 8'd0};

    // expected codes: 0..3 = link N,E,S,W; 4 = eject; 7 = not emitted
    localparam tvec_t VEC [NV] = '{
        '{3'd3,3'd3,1'b1, '{1'b1,3'd5,3'd5,8'd10}, NO, NO, NO, NO, 3'd0,XX,XX,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b0, '{1'b1,3'd5,3'd5,8'd10}, NO, NO, NO, NO, 3'd1,XX,XX,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b0, NO, '{1'b1,3'd3,3'd1,8'd4}, NO, NO, NO, XX,3'd2,XX,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b1, '{1'b1,3'd3,3'd3,8'd5}, NO, '{1'b1,3'd3,3'd3,8'd9}, NO, NO, 3'd0,XX,3'd4,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b0, '{1'b1,3'd6,3'd3,8'd3}, NO, NO, '{1'b1,3'd7,3'd3,8'd20}, NO, 3'd0,XX,XX,3'd1,XX, 1'b0},
        '{3'd3,3'd3,1'b0, '{1'b1,3'd6,3'd3,8'd7}, NO, NO, '{1'b1,3'd7,3'd3,8'd7}, NO, 3'd1,XX,XX,3'd0,XX, 1'b0},
        '{3'd3,3'd3,1'b1, '{1'b1,3'd0,3'd3,8'd1}, '{1'b1,3'd0,3'd0,8'd2}, '{1'b1,3'd3,3'd7,8'd3},
              '{1'b1,3'd7,3'd7,8'd4}, '{1'b1,3'd5,3'd5,8'd60}, 3'd3,3'd2,3'd1,3'd0,XX, 1'b1},
        '{3'd0,3'd0,1'b1, '{1'b1,3'd2,3'd2,8'd5}, NO, '{1'b1,3'd5,3'd5,8'd50}, NO, '{1'b1,3'd5,3'd0,8'd1},
              3'd0,XX,XX,XX,3'd1, 1'b0},
        '{3'd7,3'd7,1'b1, NO, NO, '{1'b1,3'd0,3'd7,8'd6}, '{1'b1,3'd7,3'd0,8'd2}, '{1'b1,3'd0,3'd0,8'd99},
              XX,XX,3'd3,3'd2,XX, 1'b1},
        '{3'd3,3'd3,1'b0, NO, '{1'b1,3'd3,3'd6,8'd3}, NO, NO, '{1'b1,3'd3,3'd7,8'd30}, XX,3'd1,XX,XX,3'd0, 1'b0},
        '{3'd3,3'd3,1'b1, '{1'b1,3'd5,3'd5,8'd9}, '{1'b1,3'd5,3'd6,8'd2}, NO, NO, NO, 3'd0,3'd1,XX,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b0, '{1'b1,3'd5,3'd5,8'd9}, '{1'b1,3'd5,3'd6,8'd2}, NO, NO, NO, 3'd1,3'd0,XX,XX,XX, 1'b0},
        '{3'd3,3'd3,1'b0, NO, NO, NO, NO, '{1'b1,3'd3,3'd3,8'd0}, XX,XX,XX,XX,3'd4, 1'b0},
        '{3'd3,3'd3,1'b1, NO, NO, '{1'b1,3'd3,3'd3,8'd4}, NO, '{1'b1,3'd3,3'd3,8'd4}, XX,XX,3'd4,XX,3'd0, 1'b0}
    };

    // requirement exercised by each vector
    localparam string VREQ [NV] = '{"R7", "R6", "R6", "R3", "R4", "R5", "R8",
                                     "R9", "R10", "R4", "R7", "R6", "R3", "R5"};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2:0]            my_x = '0, my_y = '0;
    logic                  mode_multi = 1'b0;
    logic [3:0]            in_vld = '0;
    logic [3:0][2:0]       in_dst_x = '0, in_dst_y = '0;
    logic [3:0][7:0]       in_age = '0;
    logic [3:0][15:0]      in_data = '0;
    logic                  inj_vld = 1'b0;
    logic [2:0]            inj_dst_x = '0, inj_dst_y = '0;
    logic [7:0]            inj_age = '0;
    logic [15:0]           inj_data = '0;
    logic                  inj_stall;
    logic [3:0]            out_vld;
    logic [3:0][2:0]       out_dst_x, out_dst_y;
    logic [3:0][7:0]       out_age;
    logic [3:0][15:0]      out_data;
    logic                  ej_vld;
    logic [2:0]            ej_dst_x, ej_dst_y;
    logic [7:0]            ej_age;
    logic [15:0]           ej_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    defl_allocator i_defl_allocator (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .mode_multi(mode_multi),
        .in_vld(in_vld), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_age(in_age),
        .in_data(in_data), .inj_vld(inj_vld), .inj_dst_x(inj_dst_x), .inj_dst_y(inj_dst_y),
        .inj_age(inj_age), .inj_data(inj_data), .inj_stall(inj_stall),
        .out_vld(out_vld), .out_dst_x(out_dst_x), .out_dst_y(out_dst_y), .out_age(out_age),
        .out_data(out_data), .ej_vld(ej_vld), .ej_dst_x(ej_dst_x), .ej_dst_y(ej_dst_y),
        .ej_age(ej_age), .ej_data(ej_data)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_flit(input int s, input tflit_t f, input logic [15:0] tag);
        if (s < 4) begin
            in_vld[s] = f.v; in_dst_x[s] = f.x; in_dst_y[s] = f.y;
            in_age[s] = f.age; in_data[s] = tag;
        end else begin
            inj_vld = f.v; inj_dst_x = f.x; inj_dst_y = f.y;
            inj_age = f.age; inj_data = tag;
        end
    endtask

    // locate a tagged flit on the registered outputs
    task automatic locate(input logic [15:0] tag, output logic [2:0] where,
                          output int hits, output logic [7:0] age);
        where = XX; hits = 0; age = '0;
        for (int p = 0; p < 4; p++) begin
            if (out_vld[p] && out_data[p] == tag) begin
                where = 3'(p); hits++; age = out_age[p];
            end
        end
        if (ej_vld && ej_data == tag) begin
            where = 3'd4; hits++; age = ej_age;
        end
    endtask

    task automatic clear_inputs();
        in_vld = '0; inj_vld = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tflit_t     fl [5];
        logic [2:0] ex [5];
        logic [2:0] where;
        int         hits;
        logic [7:0] age;

        // R1: outputs idle during and just after reset
        repeat (3) @(negedge clk);
        check(out_vld == '0 && !ej_vld, "R1", "valid during reset",
              int'({out_vld, ej_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == '0 && !ej_vld, "R1", "valid after reset",
              int'({out_vld, ej_vld}), 0);

        for (int v = 0; v < NV; v++) begin
            fl = '{VEC[v].f0, VEC[v].f1, VEC[v].f2, VEC[v].f3, VEC[v].f4};
            ex = '{VEC[v].e0, VEC[v].e1, VEC[v].e2, VEC[v].e3, VEC[v].e4};
            my_x = VEC[v].mx; my_y = VEC[v].my; mode_multi = VEC[v].multi;
            for (int s = 0; s < 5; s++)
                set_flit(s, fl[s], {8'(v), 8'(s)});
            #1;
            check(inj_stall == VEC[v].stall, "R10", $sformatf("stall vec %0d", v),
                  int'(inj_stall), int'(VEC[v].stall));
            @(negedge clk);
            for (int s = 0; s < 5; s++) begin
                locate({8'(v), 8'(s)}, where, hits, age);
                check(where == ex[s] && hits <= 1, VREQ[v],
                      $sformatf("vec %0d slot %0d port", v, s), int'(where), int'(ex[s]));
                if (ex[s] != XX)
                    check(age == fl[s].age + 8'd1, "R11",
                          $sformatf("vec %0d slot %0d age", v, s), int'(age),
                          int'(fl[s].age) + 1);
            end
            clear_inputs();
        end

        // R2: idle cycle emits nothing
        @(negedge clk);
        check(out_vld == '0 && !ej_vld, "R2", "idle output",
              int'({out_vld, ej_vld}), 0);

        // R11: saturation at the all-ones stamp
        my_x = 3'd3; my_y = 3'd3; mode_multi = 1'b1;
        set_flit(0, '{1'b1, 3'd5, 3'd5, 8'hFF}, 16'hAAAA);
        @(negedge clk);
        clear_inputs();
        locate(16'hAAAA, where, hits, age);
        check(where == 3'd0 && age == 8'hFF, "R11", "saturated age", int'(age), 255);

        // R1: reset pulse discards a flit already registered
        set_flit(1, '{1'b1, 3'd0, 3'd3, 8'd3}, 16'hBBBB);
        @(negedge clk);
        clear_inputs();
        check(out_vld[3] == 1'b1, "R2", "flit before reset", int'(out_vld), 8);
        rst_n = 1'b0;
        #1;
        check(out_vld == '0 && !ej_vld, "R1", "async clear",
              int'({out_vld, ej_vld}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == '0 && !ej_vld, "R1", "after second reset",
              int'({out_vld, ej_vld}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule